// File: doc/BRIEF.md
# Bus-Snooping Display Memory Mirror

This block keeps a shadow copy of part of a CPU's memory inside a separate display RAM. It watches an 8-bit CPU bus on every bus-cycle clock edge. When a write cycle targets an address inside a configurable window (by default 0x0400 to 0x7FFF inclusive), it captures the address and data. Read cycles and writes outside the window leave no trace.

Captured writes pass through a small dual-clock queue into the display clock domain, which is unrelated to the CPU clock. A divider on the display clock paces the replay. At most one write is issued into display RAM per divider period, set to one microsecond by default. The display RAM address is the low fifteen bits of the CPU address, with no offset applied.

The queue absorbs short bursts of writes. A write that arrives while the queue is full is dropped, and a sticky flag in the CPU domain records the loss.

Top module: `bus_snoop_mirror`

## Requirements
- R1: A CPU write, meaning `cpu_we` high at a rising `cpu_clk` edge, whose address lies in [WIN_LO, WIN_HI] (defaults 0x0400 and 0x7FFF, both inclusive) is mirrored. Writes at 0x03FF, 0x8000, 0xFFFF, 0x0000 or any other address outside the window produce no display write.
- R2: Bus cycles with `cpu_we` low produce no display write, whatever their address.
- R3: A mirrored write appears with `vram_addr` equal to `cpu_addr[14:0]` and `vram_data` equal to `cpu_data`.
- R4: Mirrored writes reach display RAM in the order the CPU issued them.
- R5: Two `vram_we` pulses are never closer than TICK_DIV display clocks (100 by default, which is 1 µs at 100 MHz). While writes are waiting in the queue, consecutive pulses are exactly TICK_DIV clocks apart.
- R6: Up to DEPTH (default 4) writes on consecutive CPU cycles are all delivered. A sustained stream of one write every four CPU cycles at 4 MHz is also delivered without loss, and `ovf_sticky` stays low.
- R7: A window write that arrives while DEPTH entries are held is dropped and sets `ovf_sticky`. The flag stays high until `cpu_rst_n` is asserted. Entries already queued are still delivered.
- R8: While `disp_rst_n` is low and after its release, `vram_we` is low until a captured write is replayed. `ovf_sticky` is low after `cpu_rst_n`.
- R9: Each accepted write produces exactly one single-cycle `vram_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU bus-cycle clock; the bus is sampled on its rising edge |
| cpu_rst_n | input | 1 | Active-low reset of the CPU-side logic |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_we | input | 1 | High during a CPU write cycle |
| disp_clk | input | 1 | Display-side clock, unrelated to cpu_clk |
| disp_rst_n | input | 1 | Active-low reset of the display-side logic |
| vram_addr | output | 15 | Display RAM write address |
| vram_data | output | 8 | Display RAM write data |
| vram_we | output | 1 | Display RAM write enable, one clock per write |
| ovf_sticky | output | 1 | Set when a window write was dropped because the queue was full |

## Verification
A corrupted queue pointer or a lost synchroniser update shows at the ports within a few microseconds. The symptoms are a missing, duplicated or reordered `vram_addr`/`vram_data` pair, or a display write that corresponds to no CPU write. A wrong window decode shows as a stray or absent display write within one pacing period plus a few display clocks of the offending bus cycle. A pacing divider off by one shows as a gap other than TICK_DIV clocks between backlogged writes. An overflow flag that is set, cleared or gated wrongly is visible on `ovf_sticky` in the CPU cycle after the dropped write.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int CPU_AW  = 16;
  localparam int VRAM_AW = 15;
  localparam int DW      = 8;

  typedef struct packed {
    logic [VRAM_AW-1:0] addr;
    logic [DW-1:0]      data;
  } snoop_entry_t;

  localparam int ENTRY_W = VRAM_AW + DW;

  // Inclusive window test on a CPU address
  function automatic logic in_window(input logic [CPU_AW-1:0] a,
                                     input logic [CPU_AW-1:0] lo,
                                     input logic [CPU_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Display RAM index derived from a CPU address: low bits, no offset
  function automatic logic [VRAM_AW-1:0] vram_index(input logic [CPU_AW-1:0] a);
    return a[VRAM_AW-1:0];
  endfunction
endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/snoop_capture.sv
module snoop_capture
  import snoop_pkg::*;
#(
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h0400,
  parameter logic [CPU_AW-1:0] WIN_HI = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] addr,
  input  logic [DW-1:0]     data,
  input  logic              we,
  output logic              cap_valid,
  output snoop_entry_t      cap_entry
);
  logic [CPU_AW-1:0] cap_addr_full;
  logic              hit;

  assign hit = we && in_window(addr, WIN_LO, WIN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid     <= 1'b0;
      cap_addr_full <= '0;
      cap_entry     <= '0;
    end else begin
      cap_valid <= hit;
      if (hit) begin
        cap_addr_full  <= addr;
        cap_entry.addr <= vram_index(addr);
        cap_entry.data <= data;
      end
    end
  end

  // R1: a held capture always carries an address inside the window
  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> in_window(cap_addr_full, WIN_LO, WIN_HI));

  // R2: a cycle without write strobe never yields a capture
  assert_reads_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> !cap_valid);
endmodule

// File: rtl/snoop_pacer.sv
module snoop_pacer #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  assert_tick_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/snoop_xfifo.sv
module snoop_xfifo
  import snoop_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         in_valid,
  input  snoop_entry_t in_entry,
  output logic         ovf,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_req,
  output logic         pop,
  output snoop_entry_t out_entry
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  snoop_entry_t mem [DEPTH];

  // write side
  logic [PW-1:0] wbin, wgray, rq_gray, rq_bin, w_occ;
  logic          full, push;

  snoop_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_x), .q(rq_gray));

  assign rq_bin = gray2bin(rq_gray);
  assign w_occ  = wbin - rq_bin;
  assign full   = (w_occ == DEPTH_P);
  assign push   = in_valid && !full;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin + 1'b1;
        wgray <= bin2gray(wbin + 1'b1);
      end
      if (in_valid && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge wclk)
    if (push) mem[wbin[AW-1:0]] <= in_entry;

  // read side
  logic [PW-1:0] rbin, rgray_x, wq_gray, wq_bin, r_occ;
  logic          empty;

  snoop_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq_gray));

  assign wq_bin    = gray2bin(wq_gray);
  assign r_occ     = wq_bin - rbin;
  assign empty     = (r_occ == '0);
  assign pop       = rd_req && !empty;
  assign out_entry = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray_x <= '0;
    end else if (pop) begin
      rbin    <= rbin + 1'b1;
      rgray_x <= bin2gray(rbin + 1'b1);
    end
  end

  // R6: the writer never sees more than DEPTH entries in flight
  assert_occupancy_bound_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_occ <= DEPTH_P);

  // R7: once set, the loss flag holds until reset
  assert_no_overflow_clear_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
    ovf |=> ovf);

  // R9: the reader never runs past the synchronised writer
  assert_read_bound_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_occ <= DEPTH_P);

  // R9: each pop advances the read pointer by exactly one
  assert_pop_step_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    pop |=> (rbin == $past(rbin) + 1'b1));
endmodule

// File: rtl/bus_snoop_mirror.sv
module bus_snoop_mirror
  import snoop_pkg::*;
#(
  parameter logic [15:0] WIN_LO   = 16'h0400,
  parameter logic [15:0] WIN_HI   = 16'h7FFF,
  parameter int          DEPTH    = 4,
  parameter int          TICK_DIV = 100,
  parameter int          STAGES   = 2
) (
  input  logic        cpu_clk,
  input  logic        cpu_rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_we,
  input  logic        disp_clk,
  input  logic        disp_rst_n,
  output logic [14:0] vram_addr,
  output logic [7:0]  vram_data,
  output logic        vram_we,
  output logic        ovf_sticky
);
  localparam int SW = $clog2(TICK_DIV + 1);
  localparam logic [SW-1:0] DIV_S = SW'(TICK_DIV);

  logic         cap_valid;
  snoop_entry_t cap_entry;
  logic         tick, pop;
  snoop_entry_t head;

  snoop_capture #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_cap (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .addr(cpu_addr), .data(cpu_data),
    .we(cpu_we), .cap_valid(cap_valid), .cap_entry(cap_entry));

  snoop_xfifo #(.DEPTH(DEPTH), .STAGES(STAGES)) u_q (
    .wclk(cpu_clk), .wrst_n(cpu_rst_n), .in_valid(cap_valid),
    .in_entry(cap_entry), .ovf(ovf_sticky),
    .rclk(disp_clk), .rrst_n(disp_rst_n), .rd_req(tick), .pop(pop),
    .out_entry(head));

  snoop_pacer #(.TICK_DIV(TICK_DIV)) u_pace (
    .clk(disp_clk), .rst_n(disp_rst_n), .tick(tick));

  always_ff @(posedge disp_clk or negedge disp_rst_n) begin
    if (!disp_rst_n) begin
      vram_we   <= 1'b0;
      vram_addr <= '0;
      vram_data <= '0;
    end else begin
      vram_we <= pop;
      if (pop) begin
        vram_addr <= head.addr;
        vram_data <= head.data;
      end
    end
  end

  // spacing monitor: cycles since the last display write, saturating
  logic [SW-1:0] since_we;
  always_ff @(posedge disp_clk or negedge disp_rst_n) begin
    if (!disp_rst_n)            since_we <= DIV_S;
    else if (vram_we)           since_we <= SW'(1);
    else if (since_we < DIV_S)  since_we <= since_we + 1'b1;
  end

  assert_we_spacing_R5: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
    vram_we |-> (since_we >= DIV_S));

  assert_we_pulse_R9: assert property (@(posedge disp_clk) disable iff (!disp_rst_n)
    vram_we |=> !vram_we);
endmodule

// File: tb/tb_bus_snoop_mirror.sv
`timescale 1ns/1ps
module tb_bus_snoop_mirror;
  localparam int DIV = 100;

  logic        cpu_clk = 0, disp_clk = 0;
  logic        cpu_rst_n = 0, disp_rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 0;
  logic [14:0] vram_addr;
  logic [7:0]  vram_data;
  logic        vram_we;
  logic        ovf_sticky;

  always #5   disp_clk = ~disp_clk;
  always #125 cpu_clk  = ~cpu_clk;

  bus_snoop_mirror dut (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_we(cpu_we), .disp_clk(disp_clk),
    .disp_rst_n(disp_rst_n), .vram_addr(vram_addr), .vram_data(vram_data),
    .vram_we(vram_we), .ovf_sticky(ovf_sticky));

  int n_tests = 0, n_fail = 0;
  longint dcyc = 0;

  logic [14:0] got_a [64];
  logic [7:0]  got_d [64];
  longint      got_t [64];
  int          got_n = 0;
  logic [14:0] exp_a [64];
  logic [7:0]  exp_d [64];
  int          exp_n = 0;

  always @(posedge disp_clk) dcyc <= dcyc + 1;

  always @(negedge disp_clk)
    if (vram_we && got_n < 64) begin
      got_a[got_n] = vram_addr;
      got_d[got_n] = vram_data;
      got_t[got_n] = dcyc;
      got_n++;
    end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_cycle(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge cpu_clk);
    cpu_we = we; cpu_addr = a; cpu_data = d;
  endtask

  task automatic cpu_idle(input int n);
    for (int i = 0; i < n; i++) cpu_cycle(1'b0, 16'h0000, 8'h00);
  endtask

  // one write cycle followed by three idle cycles, as a four-cycle instruction
  task automatic cpu_wr4(input logic [15:0] a, input logic [7:0] d, input bit mirrored);
    cpu_cycle(1'b1, a, d);
    cpu_idle(3);
    if (mirrored) begin
      exp_a[exp_n] = a[14:0];
      exp_d[exp_n] = d;
      exp_n++;
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n * DIV) @(posedge disp_clk);
  endtask

  task automatic reset_all();
    cpu_we = 0;
    cpu_rst_n = 0; disp_rst_n = 0;
    repeat (3) @(posedge cpu_clk);
    cpu_rst_n = 1; disp_rst_n = 1;
    repeat (2) @(posedge cpu_clk);
    got_n = 0; exp_n = 0;
  endtask

  task automatic compare(input string req, input bit exact_gap);
    check(got_n == exp_n, req, "write count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_a[i] == exp_a[i], "R3", "vram_addr", got_a[i], exp_a[i]);
      check(got_d[i] == exp_d[i], "R4", "vram_data order", got_d[i], exp_d[i]);
      if (i > 0) begin
        check(got_t[i] - got_t[i-1] >= DIV, "R5", "min spacing",
              got_t[i] - got_t[i-1], DIV);
        if (exact_gap)
          check(got_t[i] - got_t[i-1] == DIV, "R5", "backlog spacing",
                got_t[i] - got_t[i-1], DIV);
      end
    end
  endtask

  // R8: quiet outputs out of reset
  task automatic t_reset();
    reset_all();
    @(negedge disp_clk);
    check(vram_we == 1'b0, "R8", "vram_we after reset", vram_we, 0);
    @(negedge cpu_clk);
    check(ovf_sticky == 1'b0, "R8", "ovf after reset", ovf_sticky, 0);
    wait_us(3);
    check(got_n == 0, "R8", "no spontaneous write", got_n, 0);
  endtask

  // R1 window edges, R3 address mapping
  task automatic t_window();
    reset_all();
    cpu_wr4(16'h03FF, 8'h11, 0);
    cpu_wr4(16'h0400, 8'h22, 1);
    cpu_wr4(16'h8000, 8'h33, 0);
    cpu_wr4(16'h7FFF, 8'h44, 1);
    cpu_wr4(16'hFFFF, 8'h55, 0);
    cpu_wr4(16'h0000, 8'h66, 0);
    cpu_wr4(16'h1234, 8'h77, 1);
    cpu_wr4(16'hC400, 8'h88, 0);
    wait_us(6);
    compare("R1", 0);
  endtask

  // R2: read cycles to window addresses leave no trace
  task automatic t_reads();
    reset_all();
    for (int i = 0; i < 6; i++) begin
      cpu_cycle(1'b0, 16'h0400 + 16'(i * 16'h1111), 8'hA0 + 8'(i));
      cpu_idle(3);
    end
    cpu_wr4(16'h2000, 8'h5A, 1);
    wait_us(5);
    compare("R2", 0);
  endtask

  // R6, R9: sustained 4 MHz stream, one write per four cycles
  task automatic t_stream();
    reset_all();
    for (int i = 0; i < 12; i++)
      cpu_wr4(16'h0800 + 16'(i * 37), 8'(8'h30 + i), 1);
    wait_us(8);
    compare("R6", 0);
    @(negedge cpu_clk);
    check(ovf_sticky == 1'b0, "R6", "no overflow on stream", ovf_sticky, 0);
  endtask

  // R5, R6: DEPTH back-to-back writes, delivered on consecutive ticks
  task automatic t_burst();
    reset_all();
    for (int i = 0; i < 4; i++) begin
      cpu_cycle(1'b1, 16'h4000 + 16'(i), 8'(8'hC0 + i));
      exp_a[exp_n] = 15'(16'h4000 + 16'(i)); exp_d[exp_n] = 8'(8'hC0 + i); exp_n++;
    end
    cpu_idle(2);
    wait_us(7);
    compare("R9", 1);
    @(negedge cpu_clk);
    check(ovf_sticky == 1'b0, "R6", "no overflow on burst", ovf_sticky, 0);
  endtask

  // R7: drop when full, sticky flag, queued entries still delivered
  task automatic t_overflow();
    reset_all();
    disp_rst_n = 0;
    for (int i = 0; i < 6; i++) begin
      cpu_cycle(1'b1, 16'h0500 + 16'(i), 8'(8'hE0 + i));
      if (i < 4) begin
        exp_a[exp_n] = 15'(16'h0500 + 16'(i)); exp_d[exp_n] = 8'(8'hE0 + i); exp_n++;
      end
    end
    cpu_idle(3);
    @(negedge cpu_clk);
    check(ovf_sticky == 1'b1, "R7", "ovf set", ovf_sticky, 1);
    disp_rst_n = 1;
    wait_us(7);
    compare("R7", 1);
    @(negedge cpu_clk);
    check(ovf_sticky == 1'b1, "R7", "ovf held", ovf_sticky, 1);
    cpu_rst_n = 0;
    @(negedge cpu_clk);
    cpu_rst_n = 1;
    @(negedge cpu_clk);
    check(ovf_sticky == 1'b0, "R7", "ovf cleared by reset", ovf_sticky, 0);
  endtask

  bit done = 0;

  initial begin
    #1500000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_window();
    t_reads();
    t_stream();
    t_burst();
    t_overflow();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule